// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block is a synthesizable model of a single-port synchronous SRAM. It holds a small on-chip array of 32-bit words with four byte lanes. An access begins when an address is loaded by one of two address strobes: a processor strobe and a controller strobe. A chip-select decision is taken from three chip enables, but only at that load. The two low address bits then run through a 2-bit burst counter, which an advance input steps. The data bus is split into an input port, an output port and a drive flag. Read data comes straight from the array during the cycle after the address was loaded or advanced, in flow-through style. Write data given in a cycle goes to the word that is addressed during that cycle.

A four-state machine controls the block:

- `S_DESEL`: deselected. Entered from reset, and after any load that finds the chip enables invalid.
- `S_FIRST`: the first cycle after a selecting load out of `S_DESEL` or `S_SLEEP`. Output drive is masked in this state.
- `S_ACTIVE`: selected, with normal drive.
- `S_SLEEP`: entered on any edge where the sleep input is high. The next edge with sleep low goes to `S_DESEL`, or to `S_FIRST` if that edge performs a selecting load.

The named transitions are:

- **select** (`S_DESEL`/`S_SLEEP` to `S_FIRST`)
- **settle** (`S_FIRST` to `S_ACTIVE`)
- **reload** (`S_ACTIVE`/`S_FIRST` to `S_ACTIVE` on a selecting load)
- **deselect** (any awake state to `S_DESEL` on a non-selecting load)
- **doze** (any state to `S_SLEEP`)
- **wake** (`S_SLEEP` to `S_DESEL`)

Top module: `sbsram_top`

## Requirements
- R1: The address and the chip-select decision are captured on a rising edge only when an address load occurs. A load is `adsp_n`=0 together with `ce1_n`=0, or `adsc_n`=0. On any other edge the selected/deselected state is held, even if the chip enables change.
- R2: When `adsp_n` and `adsc_n` are both low (with `ce1_n`=0), the processor strobe wins. A processor-strobe load discards the write enables of that same cycle, so no lane is written at that edge.
- R3: `adsp_n` is ignored while `ce1_n`=1: no load occurs and the address is held. In that same cycle, `adsc_n`=0 still loads the address and takes the select decision.
- R4: The block is selected only if a load sees `ce1_n`=0, `ce2`=1 and `ce3_n`=0 together. While the block is deselected it never drives `dout_en` and never writes the array.
- R5: Every load sets the word index to `addr`, with the burst counter taking `addr[1:0]`. While selected, each edge with `adv_n`=0 and no load adds one to the counter. During the cycle after a load or advance, `dout` shows the addressed word.
- R6: The counter wraps modulo 4 in linear order (3 is followed by 0). Only the two low index bits change, and `addr[AW-1:2]` stays as captured.
- R7: Write data `din` in a cycle goes to the word addressed during that cycle. `gw_n`=0 writes all four lanes, whatever `bwe_n` and `bw_n` are. Otherwise lane i (`din[8i+7:8i]`) is written only when `bwe_n`=0 and `bw_n[i]`=0.
- R8: `dout_en` is 1 only in `S_ACTIVE` with `oe_n`=0, sleep low and no write requested in the cycle. A write is requested by `gw_n`=0, or by `bwe_n`=0 with any `bw_n` bit low. `dout_en` is forced to 0 in the first cycle after a selecting load out of the deselected state. When `dout_en` is 0, `dout` is 0.
- R9: While `zz`=1 nothing is written, nothing is loaded or advanced, and `dout_en` is 0. The array contents are kept. After sleep the block is deselected until a new load.
- R10: Synchronous active-low reset `rst_n` puts the block in `S_DESEL` with index 0, so `dout_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all synchronous inputs sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Word address |
| adsp_n | input | 1 | Processor address strobe, active low |
| adsc_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low (also gates the processor strobe) |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Output enable, asynchronous, active low |
| zz | input | 1 | Sleep, active high |
| din | input | 8*LANES | Write data |
| dout | output | 8*LANES | Read data, zero when not driven |
| dout_en | output | 1 | Data port drive flag |

## Verification
The hardest cases to reach are the ones that leave no direct trace: a strobe collision, a processor strobe blocked by chip enable 1, and a write request during sleep. Each of these shows up only as the absence of a write or a load. To expose them, the stimulus first fills the whole array with known words. It then places a clashing strobe pair, or a blocked strobe, next to a write request aimed at a word whose value is known. It then reloads and reads that word back, along with the newly loaded word, so that a write or load that should not have happened shows up at the data port. Burst wraparound is driven by starting bursts at counter values 1 and 2, so that both reads and writes cross the step from 3 to 0.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
    typedef enum logic [1:0] {
        S_DESEL,
        S_FIRST,
        S_ACTIVE,
        S_SLEEP
    } sb_state_e;

    localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/sbsram_fsm.sv
module sbsram_fsm
    import sbsram_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adsp_n,
    input  logic             adsc_n,
    input  logic             adv_n,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             oe_n,
    input  logic             zz,
    output logic             load,
    output logic             adv_step,
    output logic [LANES-1:0] lane_we,
    output logic             drive
);
    sb_state_e        state, nxt;
    logic             load_p, load_c, ce_ok, selected;
    logic [LANES-1:0] lanes_req;

    assign load_p   = !adsp_n && !ce1_n && !zz;
    assign load_c   = !adsc_n && !load_p && !zz;
    assign load     = load_p || load_c;
    assign ce_ok    = !ce1_n && ce2 && !ce3_n;
    assign selected = (state == S_FIRST) || (state == S_ACTIVE);

    always_comb begin
        nxt = state;
        if (zz) begin
            nxt = S_SLEEP;
        end else begin
            unique case (state)
                S_DESEL, S_SLEEP: nxt = (load && ce_ok) ? S_FIRST : S_DESEL;
                S_FIRST, S_ACTIVE: begin
                    if (load) nxt = ce_ok ? S_ACTIVE : S_DESEL;
                    else      nxt = S_ACTIVE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_DESEL;
        else        state <= nxt;
    end

    always_comb begin
        if (!gw_n)       lanes_req = '1;
        else if (!bwe_n) lanes_req = ~bw_n;
        else             lanes_req = '0;
        adv_step = selected && !zz && !load && !adv_n;
        lane_we  = (selected && !zz && !load_p) ? lanes_req : '0;
        drive    = (state == S_ACTIVE) && !oe_n && !zz && (lanes_req == '0);
    end

    // first read after a selecting load from deselect is masked
    assert_first_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && load && ce_ok && !selected) |=> !drive);

    // non-selecting load leaves the port undriven next cycle
    assert_desel_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!zz && load && !ce_ok) |=> !drive);

    // strobe collision: processor wins, same-cycle writes dropped
    assert_adsp_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce1_n && !adsc_n && !zz) |-> (lane_we == '0));

    // sleep blocks drive and writes
    assert_sleep_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        zz |-> (!drive && lane_we == '0));
endmodule

// File: rtl/sbsram_addr.sv
module sbsram_addr #(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv_step,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] word_idx,
    output logic [AW-3:0] addr_hi,
    output logic [1:0]    burst
);
    localparam int unsigned HW = AW - 2;

    logic [HW-1:0] hi_q;
    logic [1:0]    cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            hi_q  <= addr_in[AW-1:2];
            cnt_q <= addr_in[1:0];
        end else if (adv_step) begin
            cnt_q <= cnt_q + 2'd1;
        end
    end

    assign addr_hi  = hi_q;
    assign burst    = cnt_q;
    assign word_idx = {hi_q, cnt_q};
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int unsigned AW    = 6,
    parameter int unsigned LANES = 4
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        lane_we,
    input  logic [AW-1:0]           widx,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int unsigned WORDS = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [WORDS];

        always_ff @(posedge clk) begin
            if (lane_we[g]) bank[widx] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = bank[widx];
    end
endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int unsigned AW    = 6,
    parameter int unsigned LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    adsp_n,
    input  logic                    adsc_n,
    input  logic                    adv_n,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    oe_n,
    input  logic                    zz,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int unsigned DW = LANES * LANE_W;

    logic             load, adv_step, drive;
    logic [LANES-1:0] lane_we;
    logic [AW-1:0]    word_idx;
    logic [AW-3:0]    addr_hi;
    logic [1:0]       burst;
    logic [DW-1:0]    rdata;

    sbsram_fsm #(.LANES(LANES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .zz(zz),
        .load(load), .adv_step(adv_step), .lane_we(lane_we), .drive(drive)
    );

    sbsram_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load), .adv_step(adv_step),
        .addr_in(addr), .word_idx(word_idx), .addr_hi(addr_hi), .burst(burst)
    );

    sbsram_array #(.AW(AW), .LANES(LANES)) u_array (
        .clk(clk), .lane_we(lane_we), .widx(word_idx), .wdata(din), .rdata(rdata)
    );

    assign dout    = drive ? rdata : '0;
    assign dout_en = drive;

    // upper address only changes on a load
    assert_hold_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(addr_hi));

    // blocked processor strobe leaves the index untouched
    assert_adsp_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && ce1_n && adsc_n && adv_n) |=> $stable(word_idx));

    // advance steps the 2-bit counter with wrap
    assert_burst_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adv_step |=> (burst == $past(burst) + 2'd1) && $stable(addr_hi));

    // sleep freezes the address
    assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        zz |=> $stable(word_idx));
endmodule

// File: tb/sbsram_top_tb.sv
`timescale 1ns/1ps
module sbsram_top_tb;
    localparam int AW = 6;
    localparam int LANES = 4;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, adsp_n, adsc_n, adv_n, ce1_n, ce2, ce3_n, gw_n, bwe_n, oe_n, zz;
    logic [AW-1:0] addr;
    logic [LANES-1:0] bw_n;
    logic [DW-1:0] din, dout;
    logic dout_en;

    sbsram_top #(.AW(AW), .LANES(LANES)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .zz(zz), .din(din),
        .dout(dout), .dout_en(dout_en)
    );

    logic [DW-1:0] ref_mem [1<<AW];
    logic          q_en   [$];
    logic [DW-1:0] q_data [$];
    string         q_tag  [$];
    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    always @(negedge clk) begin
        if (q_en.size() != 0) begin
            logic e;
            logic [DW-1:0] d;
            string t;
            e = q_en.pop_front();
            d = q_data.pop_front();
            t = q_tag.pop_front();
            compared++;
            if (e) begin
                if (dout_en !== 1'b1 || dout !== d) begin
                    mismatched++;
                    $display("FAIL %s: got en=%b data=%h, expected en=1 data=%h", t, dout_en, dout, d);
                end
            end else if (dout_en !== 1'b0) begin
                mismatched++;
                $display("FAIL %s: got en=%b, expected en=0", t, dout_en);
            end
        end
    end

    task automatic idle();
        adsp_n = 1; adsc_n = 1; adv_n = 1; ce1_n = 0; ce2 = 1; ce3_n = 0;
        gw_n = 1; bwe_n = 1; bw_n = '1; oe_n = 1; zz = 0; addr = '0; din = '0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic expect_out(input logic en, input logic [DW-1:0] d, input string tag);
        q_en.push_back(en); q_data.push_back(d); q_tag.push_back(tag);
    endtask

    task automatic load_c(input int a);
        idle(); adsc_n = 0; addr = AW'(a); tick();
    endtask

    task automatic load_p(input int a);
        idle(); adsp_n = 0; addr = AW'(a); tick();
    endtask

    task automatic write_word(input int a, input logic [DW-1:0] d);
        load_c(a);
        idle(); gw_n = 0; din = d; tick();
        ref_mem[a] = d;
    endtask

    task automatic rd(input logic en, input int a, input logic adv, input string tag);
        idle(); oe_n = 0; adv_n = ~adv;
        expect_out(en, ref_mem[a], tag);
        tick();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        idle(); rst_n = 0; oe_n = 0;
        tick(); tick();
        expect_out(0, '0, "R10 reset undriven");
        tick();
        rst_n = 1;

        // fill array using global writes (R7)
        for (int i = 0; i < (1<<AW); i++) write_word(i, 32'hA500_0000 ^ (i * 32'h0101_0101));

        // burst read wrapping from counter 2 (R5, R6)
        load_p(6);
        rd(1, 6, 1, "R5 burst read first");
        rd(1, 7, 1, "R5 burst read step");
        rd(1, 4, 1, "R6 read wrap 3->0");
        rd(1, 5, 0, "R6 read after wrap");

        // burst write wrapping from counter 1 (R6, R7)
        load_c(13);
        for (int k = 0; k < 4; k++) begin
            int w;
            w = 12 + ((1 + k) % 4);
            idle(); gw_n = 0; adv_n = 0; din = 32'hC0DE_0000 + k;
            tick();
            ref_mem[w] = 32'hC0DE_0000 + k;
        end
        load_p(12);
        rd(1, 12, 1, "R6 write wrap word 12");
        rd(1, 13, 1, "R6 write word 13");
        rd(1, 14, 1, "R6 write word 14");
        rd(1, 15, 0, "R6 write word 15");

        // byte lanes (R7) and drive masked while writing (R8)
        load_c(30);
        idle(); bwe_n = 0; bw_n = 4'b1010; din = 32'hFFFF_FFFF; oe_n = 0;
        expect_out(0, '0, "R8 no drive during write");
        tick();
        ref_mem[30] = (ref_mem[30] & 32'hFF00_FF00) | 32'h00FF_00FF;
        idle(); bwe_n = 1; bw_n = 4'b0000; din = 32'h0; tick();
        rd(1, 30, 0, "R7 lanes 0,2 only, bwe_n high ignored");
        load_c(31);
        idle(); gw_n = 0; bwe_n = 0; bw_n = 4'b1110; din = 32'h1234_5678; tick();
        ref_mem[31] = 32'h1234_5678;
        rd(1, 31, 0, "R7 global write all lanes");

        // strobe collision (R2)
        load_c(40);
        idle(); adsp_n = 0; adsc_n = 0; addr = 6'd41; gw_n = 0; din = 32'hDEAD_DEAD; tick();
        rd(1, 41, 0, "R2 processor load took effect");
        load_p(40);
        rd(1, 40, 0, "R2 same-cycle write discarded");

        // processor strobe gated by ce1_n (R3)
        idle(); adsp_n = 0; ce1_n = 1; addr = 6'd50; tick();
        rd(1, 40, 0, "R3 gated processor strobe ignored");
        idle(); adsp_n = 0; ce1_n = 1; adsc_n = 0; addr = 6'd51; tick();
        rd(0, 51, 0, "R3 controller load deselects");
        idle(); gw_n = 0; din = 32'hBAD0_BAD0; tick();
        rd(0, 51, 0, "R1 no reselect without strobe");
        load_p(51);
        rd(0, 51, 0, "R8 first read masked");
        rd(1, 51, 0, "R4 deselected write ignored");

        // ce3_n invalid at load (R4)
        idle(); adsc_n = 0; ce3_n = 1; addr = 6'd52; tick();
        rd(0, 52, 0, "R4 ce3_n high deselects");
        idle(); adsc_n = 0; ce2 = 0; addr = 6'd53; tick();
        rd(0, 53, 0, "R4 ce2 low deselects");

        // sleep (R9)
        load_p(60);
        rd(0, 60, 0, "R8 mask after deselect");
        rd(1, 60, 0, "R9 pre-sleep read");
        idle(); zz = 1; oe_n = 0; gw_n = 0; din = 32'hBAD1_BAD1;
        expect_out(0, '0, "R9 sleep undriven");
        tick();
        idle(); zz = 1; oe_n = 0; adsp_n = 0; addr = 6'd61;
        expect_out(0, '0, "R9 sleep held");
        tick();
        rd(0, 60, 0, "R9 wake deselected");
        load_p(60);
        rd(0, 60, 0, "R8 mask after wake");
        rd(1, 60, 0, "R9 contents retained");

        idle(); tick(); tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule